// File: doc/BRIEF.md
# Sequential Multiply, Divide and Normalize Unit

This block is an arithmetic extension that sits beside a 12-bit accumulator machine. It works on a 24-bit register pair: an accumulator half (AC, the high word) and a multiplier-quotient half (MQ, the low word). A 5-bit step counter (SC) goes with the pair. On an accepted start it copies the host's AC, MQ and link values and runs one of eight commands. The long commands take one bit per clock. These are an unsigned 12x12 multiply, a 24/12 restoring divide, a normalize that counts its shifts into SC, and left, arithmetic-right and logical-right shifts of the pair. The short commands load SC from the operand or copy SC into AC.

The host drives a command code, a 12-bit operand (the multiplicand, the divisor, the shift count or the SC value) and a one-cycle start. While the unit works it holds busy high. When the result is ready it pulses done for one cycle. The results then stay on the outputs until the next accepted start. The host fetches any extra instruction word and decodes the operating mode. A single count-encoding input tells the unit whether a shift count means "places" or "places minus one".

Top module: `xarith_unit`

## Requirements
- R1: A synchronous reset, at any time, clears ac, mq, sc and link to zero and drops busy and done.
- R2: Command 0 (multiply) leaves the unsigned product mq_in x operand in {ac,mq}, with ac holding the high 12 bits. It copies link_in to link and leaves sc unchanged. done rises 12 clock edges after the edge that accepts start.
- R3: Command 1 (divide) applies when ac_in < operand. It divides the 24-bit value {ac_in,mq_in} by operand and leaves the quotient in mq and the remainder in ac. It clears link. done rises 12 edges after acceptance.
- R4: Command 1 with ac_in >= operand, which includes a zero divisor, sets link and leaves ac = ac_in and mq = mq_in. The accepting edge itself raises done.
- R5: Command 2 (normalize) shifts {ac,mq} left with zero fill. It stops once ac[11] differs from ac[10], or once ac = 12'hC00 with mq = 0. sc is the number of shifts and link is link_in. After s shifts, done rises s+1 edges after acceptance.
- R6: Normalize of an all-zero pair stops after 23 shifts, with sc = 23 and the pair still zero.
- R7: Command 3 shifts {ac,mq} left by the given number of places with zero fill. link is link_in and sc is unchanged.
- R8: Command 4 shifts {ac,mq} right and copies ac[11] into the vacated bits. Each place moves ac[0] into mq[11].
- R9: Command 5 shifts {ac,mq} right and fills with zeros. Each place moves ac[0] into mq[11].
- R10: With cnt_m1 = 0 the shift count is operand[4:0]. A count of 0 leaves the pair unchanged, and the accepting edge raises done. With cnt_m1 = 1 the count is operand[4:0] + 1. A shift of p places raises done p edges after acceptance.
- R11: Command 6 loads sc from operand[4:0] and passes ac_in and mq_in through. Command 7 sets ac to sc zero-extended and passes mq_in through. For both commands the accepting edge raises done.
- R12: start is accepted only while busy is low, and a start during busy has no effect on the result. done lasts one cycle. Outputs hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a command; ignored while busy |
| cmd | input | 3 | Command code (0 mul, 1 div, 2 norm, 3 shl, 4 asr, 5 lsr, 6 load sc, 7 sc to ac) |
| cnt_m1 | input | 1 | Shift count is places minus one when high |
| operand | input | 12 | Multiplicand, divisor, shift count or SC value |
| ac_in | input | 12 | Host AC value taken at start |
| mq_in | input | 12 | Host MQ value taken at start |
| link_in | input | 1 | Host link value taken at start |
| ac | output | 12 | Result high word |
| mq | output | 12 | Result low word |
| sc | output | 5 | Step counter |
| link | output | 1 | Result link |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle result-ready pulse |

## Verification
A wrong step count or a mis-sequenced iteration shows up at the ports in the cycle that done rises. The result pair is shifted or misaligned, and done rises earlier or later than the fixed or data-dependent latency. Both effects are visible within 33 clocks of the start. A bad overflow decision is easier to see: it flips link and overwrites the pair when it should hold it, or holds it when it should not. A step counter that does not clear or advance correctly first shows in normalize's sc value. It shows again when a later copy command puts sc into ac.

// File: rtl/xarith_pkg.sv
package xarith_pkg;
    localparam int W          = 12;
    localparam int SCW        = 5;
    localparam int CNTW       = SCW + 1;
    localparam int NORM_LIMIT = 2 * W - 1;

    typedef enum logic [2:0] {
        OP_MUL  = 3'd0,
        OP_DIV  = 3'd1,
        OP_NORM = 3'd2,
        OP_SHL  = 3'd3,
        OP_ASR  = 3'd4,
        OP_LSR  = 3'd5,
        OP_LDSC = 3'd6,
        OP_SCAC = 3'd7
    } xop_e;

    typedef struct packed {
        logic [W-1:0] hi;
        logic [W-1:0] lo;
    } pair_t;

    // One shift-add iteration: add multiplicand when low bit set, then shift right with carry.
    function automatic pair_t mul_step(pair_t p, logic [W-1:0] m);
        logic [W:0] s;
        pair_t      r;
        s    = {1'b0, p.hi} + (p.lo[0] ? {1'b0, m} : {(W+1){1'b0}});
        r.hi = s[W:1];
        r.lo = {s[0], p.lo[W-1:1]};
        return r;
    endfunction

    // One restoring division iteration producing one quotient bit in the low end.
    function automatic pair_t div_step(pair_t p, logic [W-1:0] d);
        logic [W:0] part;
        logic       ge;
        pair_t      r;
        part = {p.hi, p.lo[W-1]};
        ge   = part >= {1'b0, d};
        if (ge)
            part = part - {1'b0, d};
        r.hi = part[W-1:0];
        r.lo = {p.lo[W-2:0], ge};
        return r;
    endfunction

    function automatic logic div_ovf(logic [W-1:0] hi, logic [W-1:0] d);
        return hi >= d;
    endfunction

    function automatic logic norm_done(pair_t p);
        logic differ, minus_edge;
        differ     = p.hi[W-1] ^ p.hi[W-2];
        minus_edge = (p.hi[W-1:W-2] == 2'b11) && (p.hi[W-3:0] == '0) && (p.lo == '0);
        return differ || minus_edge;
    endfunction

    function automatic pair_t shift_step(xop_e k, pair_t p);
        logic [2*W-1:0] v;
        v = p;
        case (k)
            OP_ASR:  v = {p.hi[W-1], v[2*W-1:1]};
            OP_LSR:  v = {1'b0, v[2*W-1:1]};
            default: v = {v[2*W-2:0], 1'b0};
        endcase
        return pair_t'(v);
    endfunction
endpackage

// File: rtl/xarith_ctl.sv
module xarith_ctl
    import xarith_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  xop_e         cmd,
    input  logic [W-1:0] operand,
    input  logic [W-1:0] ac_in,
    input  logic         cnt_m1,
    input  logic         halt,
    output logic         accept,
    output logic         step,
    output logic         busy,
    output logic         done,
    output xop_e         cur
);
    logic [CNTW-1:0] cnt;
    logic [CNTW-1:0] cnt_init;
    logic            instant;
    logic            fin;

    always_comb begin
        accept = start && !busy;
        case (cmd)
            OP_MUL, OP_DIV:         cnt_init = CNTW'(W);
            OP_SHL, OP_ASR, OP_LSR: cnt_init = CNTW'(operand[SCW-1:0]) + CNTW'(cnt_m1);
            default:                cnt_init = '0;
        endcase
        case (cmd)
            OP_LDSC, OP_SCAC:       instant = 1'b1;
            OP_DIV:                 instant = div_ovf(ac_in, operand);
            OP_SHL, OP_ASR, OP_LSR: instant = (cnt_init == '0);
            default:                instant = 1'b0;
        endcase
        step = busy && !((cur == OP_NORM) && halt);
        fin  = busy && ((cur == OP_NORM) ? halt : (cnt == CNTW'(1)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            cur  <= OP_MUL;
        end else begin
            done <= (accept && instant) || fin;
            if (accept) begin
                cur  <= cmd;
                cnt  <= cnt_init;
                busy <= !instant;
            end else if (fin) begin
                busy <= 1'b0;
            end else if (step) begin
                cnt <= cnt - CNTW'(1);
            end
        end
    end
endmodule

// File: rtl/xarith_dp.sv
module xarith_dp
    import xarith_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           accept,
    input  logic           step,
    input  xop_e           cmd,
    input  xop_e           cur,
    input  logic [W-1:0]   operand,
    input  logic [W-1:0]   ac_in,
    input  logic [W-1:0]   mq_in,
    input  logic           link_in,
    output pair_t          pr,
    output logic [SCW-1:0] sc,
    output logic           link,
    output logic           halt
);
    logic [W-1:0] opnd;

    always_comb halt = norm_done(pr) || (sc == SCW'(NORM_LIMIT));

    always_ff @(posedge clk) begin
        if (rst) begin
            pr   <= '0;
            opnd <= '0;
            sc   <= '0;
            link <= 1'b0;
        end else if (accept) begin
            opnd <= operand;
            link <= (cmd == OP_DIV) ? div_ovf(ac_in, operand) : link_in;
            case (cmd)
                OP_MUL:  pr <= '{hi: '0, lo: mq_in};
                OP_SCAC: pr <= '{hi: {{(W-SCW){1'b0}}, sc}, lo: mq_in};
                default: pr <= '{hi: ac_in, lo: mq_in};
            endcase
            case (cmd)
                OP_LDSC: sc <= operand[SCW-1:0];
                OP_NORM: sc <= '0;
                default: sc <= sc;
            endcase
        end else if (step) begin
            case (cur)
                OP_MUL:  pr <= mul_step(pr, opnd);
                OP_DIV:  pr <= div_step(pr, opnd);
                OP_NORM: begin
                    pr <= shift_step(OP_SHL, pr);
                    sc <= sc + SCW'(1);
                end
                default: pr <= shift_step(cur, pr);
            endcase
        end
    end
endmodule

// File: rtl/xarith_unit.sv
module xarith_unit
    import xarith_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [2:0]     cmd,
    input  logic           cnt_m1,
    input  logic [W-1:0]   operand,
    input  logic [W-1:0]   ac_in,
    input  logic [W-1:0]   mq_in,
    input  logic           link_in,
    output logic [W-1:0]   ac,
    output logic [W-1:0]   mq,
    output logic [SCW-1:0] sc,
    output logic           link,
    output logic           busy,
    output logic           done
);
    xop_e  cmd_k;
    xop_e  cur;
    logic  accept;
    logic  step;
    logic  halt;
    pair_t pr;

    assign cmd_k = xop_e'(cmd);
    assign ac    = pr.hi;
    assign mq    = pr.lo;

    xarith_ctl u_ctl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cmd     (cmd_k),
        .operand (operand),
        .ac_in   (ac_in),
        .cnt_m1  (cnt_m1),
        .halt    (halt),
        .accept  (accept),
        .step    (step),
        .busy    (busy),
        .done    (done),
        .cur     (cur)
    );

    xarith_dp u_dp (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .step    (step),
        .cmd     (cmd_k),
        .cur     (cur),
        .operand (operand),
        .ac_in   (ac_in),
        .mq_in   (mq_in),
        .link_in (link_in),
        .pr      (pr),
        .sc      (sc),
        .link    (link),
        .halt    (halt)
    );
endmodule

// File: rtl/xarith_chk.sv
module xarith_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [2:0]  cmd,
    input logic [11:0] operand,
    input logic [11:0] ac_in,
    input logic [11:0] mq_in,
    input logic        link_in,
    input logic [11:0] ac,
    input logic [11:0] mq,
    input logic [4:0]  sc,
    input logic        link,
    input logic        busy,
    input logic        done
);
    logic        acc;
    logic [2:0]  kind_q;
    logic [23:0] prod_q;
    logic [11:0] quo_q;
    logic [11:0] rem_q;
    logic        ovf_q;
    logic        lk_q;
    logic [23:0] dvd;
    logic [23:0] qf;
    logic [23:0] rf;

    always_comb begin
        acc = start && !busy;
        dvd = {ac_in, mq_in};
        if (operand != 12'd0) begin
            qf = dvd / {12'd0, operand};
            rf = dvd % {12'd0, operand};
        end else begin
            qf = '0;
            rf = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= '0;
            prod_q <= '0;
            quo_q  <= '0;
            rem_q  <= '0;
            ovf_q  <= 1'b0;
            lk_q   <= 1'b0;
        end else if (acc) begin
            kind_q <= cmd;
            prod_q <= {12'd0, mq_in} * {12'd0, operand};
            quo_q  <= qf[11:0];
            rem_q  <= rf[11:0];
            ovf_q  <= ac_in >= operand;
            lk_q   <= link_in;
        end
    end

    // R2
    mul_result_chk: assert property (@(posedge clk) disable iff (rst)
        (done && kind_q == 3'd0) |-> ({ac, mq} == prod_q && link == lk_q));

    // R3
    div_result_chk: assert property (@(posedge clk) disable iff (rst)
        (done && kind_q == 3'd1 && !ovf_q) |-> (mq == quo_q && ac == rem_q && !link));

    // R4
    div_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd == 3'd1 && ac_in >= operand) |=>
        (done && link && ac == $past(ac_in) && mq == $past(mq_in)));

    // R5
    norm_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (done && kind_q == 3'd2) |->
        ((ac[11] != ac[10]) || (ac == 12'hC00 && mq == 12'd0) || (sc == 5'd23)));

    // R6
    norm_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (done && kind_q == 3'd2) |-> (sc <= 5'd23));

    // R11
    ldsc_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd == 3'd6) |=> (done && sc == $past(operand[4:0])));

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

bind xarith_unit xarith_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .cmd     (cmd),
    .operand (operand),
    .ac_in   (ac_in),
    .mq_in   (mq_in),
    .link_in (link_in),
    .ac      (ac),
    .mq      (mq),
    .sc      (sc),
    .link    (link),
    .busy    (busy),
    .done    (done)
);

// File: tb/xarith_unit_test.sv
`timescale 1ns/1ps
module xarith_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  cmd = '0;
    logic        cnt_m1 = 1'b0;
    logic [11:0] operand = '0;
    logic [11:0] ac_in = '0;
    logic [11:0] mq_in = '0;
    logic        link_in = 1'b0;
    logic [11:0] ac;
    logic [11:0] mq;
    logic [4:0]  sc;
    logic        link;
    logic        busy;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    xarith_unit uut (
        .clk(clk), .rst(rst), .start(start), .cmd(cmd), .cnt_m1(cnt_m1),
        .operand(operand), .ac_in(ac_in), .mq_in(mq_in), .link_in(link_in),
        .ac(ac), .mq(mq), .sc(sc), .link(link), .busy(busy), .done(done)
    );

    typedef struct packed {
        logic [2:0]  c;
        logic        m1;
        logic        li;
        logic [11:0] op;
        logic [11:0] a;
        logic [11:0] m;
        logic [11:0] ea;
        logic [11:0] em;
        logic [4:0]  esc;
        logic        el;
        logic [5:0]  lat;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [0:NV-1] = '{
        '{3'd6, 1'b0, 1'b0, 12'h015, 12'h123, 12'h456, 12'h123, 12'h456, 5'd21, 1'b0, 6'd1},
        '{3'd7, 1'b0, 1'b0, 12'h000, 12'hFFF, 12'h0AB, 12'h015, 12'h0AB, 5'd21, 1'b0, 6'd1},
        '{3'd0, 1'b0, 1'b1, 12'h00F, 12'h777, 12'h011, 12'h000, 12'h0FF, 5'd21, 1'b1, 6'd13},
        '{3'd0, 1'b0, 1'b0, 12'hFFF, 12'h000, 12'hFFF, 12'hFFE, 12'h001, 5'd21, 1'b0, 6'd13},
        '{3'd1, 1'b0, 1'b1, 12'h003, 12'h001, 12'h000, 12'h001, 12'h555, 5'd21, 1'b0, 6'd13},
        '{3'd1, 1'b0, 1'b0, 12'h005, 12'h005, 12'h123, 12'h005, 12'h123, 5'd21, 1'b1, 6'd1},
        '{3'd2, 1'b0, 1'b0, 12'h000, 12'h000, 12'h001, 12'h400, 12'h000, 5'd22, 1'b0, 6'd24},
        '{3'd2, 1'b0, 1'b1, 12'h000, 12'hE00, 12'h000, 12'hC00, 12'h000, 5'd1,  1'b1, 6'd3},
        '{3'd2, 1'b0, 1'b0, 12'h000, 12'h000, 12'h000, 12'h000, 12'h000, 5'd23, 1'b0, 6'd25},
        '{3'd2, 1'b0, 1'b0, 12'h000, 12'h400, 12'h000, 12'h400, 12'h000, 5'd0,  1'b0, 6'd2},
        '{3'd3, 1'b0, 1'b0, 12'h004, 12'h123, 12'h456, 12'h234, 12'h560, 5'd0,  1'b0, 6'd5},
        '{3'd4, 1'b1, 1'b0, 12'h003, 12'h876, 12'h543, 12'hF87, 12'h654, 5'd0,  1'b0, 6'd5},
        '{3'd5, 1'b0, 1'b0, 12'h008, 12'h876, 12'h543, 12'h008, 12'h765, 5'd0,  1'b0, 6'd9},
        '{3'd3, 1'b0, 1'b0, 12'h000, 12'hABC, 12'hDEF, 12'hABC, 12'hDEF, 5'd0,  1'b0, 6'd1},
        '{3'd4, 1'b1, 1'b0, 12'h01F, 12'h800, 12'h001, 12'hFFF, 12'hFFF, 5'd0,  1'b0, 6'd33},
        '{3'd5, 1'b0, 1'b0, 12'h018, 12'hFFF, 12'hFFF, 12'h000, 12'h000, 5'd0,  1'b0, 6'd25},
        '{3'd3, 1'b1, 1'b0, 12'h000, 12'h001, 12'h800, 12'h003, 12'h000, 5'd0,  1'b0, 6'd2},
        '{3'd4, 1'b0, 1'b0, 12'h001, 12'h801, 12'h000, 12'hC00, 12'h800, 5'd0,  1'b0, 6'd2},
        '{3'd5, 1'b0, 1'b0, 12'h001, 12'h801, 12'h000, 12'h400, 12'h800, 5'd0,  1'b0, 6'd2},
        '{3'd1, 1'b0, 1'b0, 12'h000, 12'h000, 12'h777, 12'h000, 12'h777, 5'd0,  1'b1, 6'd1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(vec_t v);
        case (v.c)
            3'd0: return "R2";
            3'd1: return v.el ? "R4" : "R3";
            3'd2: return (v.esc == 5'd23) ? "R6" : "R5";
            3'd3: return (v.m1 || v.op[4:0] == 5'd0) ? "R10" : "R7";
            3'd4: return (v.m1 || v.op[4:0] == 5'd0) ? "R10" : "R8";
            3'd5: return (v.m1 || v.op[4:0] == 5'd0) ? "R10" : "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic run_op(input logic [2:0] c, input logic m1, input logic [11:0] op,
                          input logic [11:0] a, input logic [11:0] m, input logic li,
                          output int lat);
        @(negedge clk);
        cmd = c; cnt_m1 = m1; operand = op; ac_in = a; mq_in = m; link_in = li;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [11:0] hold_ac, hold_mq;
        logic [4:0]  hold_sc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 ac", 32'(ac), 32'h0);
        check("R1 mq", 32'(mq), 32'h0);
        check("R1 sc", 32'(sc), 32'h0);
        check("R1 link/busy/done", {29'd0, link, busy, done}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            run_op(v.c, v.m1, v.op, v.a, v.m, v.li, lat);
            check(tag_of(v), {8'd0, ac, mq}, {8'd0, v.ea, v.em});
            check(tag_of(v), {26'd0, sc, link}, {26'd0, v.esc, v.el});
            if (v.lat != 6'd0)
                check(tag_of(v), 32'(lat), 32'(v.lat));
        end

        for (int i = 0; i < 16; i++) begin
            int a, m, d, hi, dvd, prod;
            a = (i * 1237 + 91) % 4096;
            m = (i * 2749 + 7) % 4096;
            prod = a * m;
            run_op(3'd0, 1'b0, 12'(a), 12'hAAA, 12'(m), 1'b0, lat);
            check("R2 product", {8'd0, ac, mq}, 32'(prod));
            check("R2 latency", 32'(lat), 32'd13);
            d  = (i * 383 + 5) % 4096;
            hi = m % d;
            dvd = hi * 4096 + a;
            run_op(3'd1, 1'b0, 12'(d), 12'(hi), 12'(a), 1'b1, lat);
            check("R3 quotient", 32'(mq), 32'(dvd / d));
            check("R3 remainder", 32'(ac), 32'(dvd % d));
            check("R3 link", 32'(link), 32'd0);
        end

        // R12 start during busy ignored
        hold_sc = sc;
        @(negedge clk);
        cmd = 3'd0; cnt_m1 = 1'b0; operand = 12'h0CD; ac_in = 12'h000; mq_in = 12'h0AB; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        cmd = 3'd6; operand = 12'h01F; mq_in = 12'h111; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        check("R12 busy start product", {8'd0, ac, mq}, 32'h0088EF);
        check("R12 busy start sc", 32'(sc), 32'(hold_sc));
        hold_ac = ac; hold_mq = mq;
        @(negedge clk);
        check("R12 done pulse", 32'(done), 32'd0);
        repeat (3) @(negedge clk);
        check("R12 hold", {8'd0, ac, mq}, {8'd0, hold_ac, hold_mq});

        // R1 reset mid-operation
        @(negedge clk);
        cmd = 3'd0; operand = 12'h123; mq_in = 12'h456; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid reset busy/done", {30'd0, busy, done}, 32'h0);
        check("R1 mid reset pair", {8'd0, ac, mq}, 32'h0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule